// File: doc/BRIEF.md
# Vector Register Lane ALU

This block holds three vector registers and runs register-to-register arithmetic on them. Each register carries four lanes of 24-bit two's-complement values. A start strobe brings in a 2-bit operation code and two 4-bit register numbers. The block reads both source registers, computes every lane and writes the result back to one register. It then pulses done. With the done pulse it can flag one of two errors: a register number that names no register, or a zero divisor.

Add, subtract and multiply finish in a fixed two-edge sequence. Divide runs through one signed restoring divider that serves the lanes in turn. The divider checks every divisor lane before it starts, so a zero in any lane cancels the whole write. A load port and a read port give the surrounding load/store logic access to the registers. A commit from the block has priority over a load that targets the same register on the same edge.

Top module: `vec_alu`

## Requirements
- R1: After reset every lane of every register reads zero, and busy_o, done_o, div0_o and bad_reg_o are low.
- R2: Register numbers 4'd0, 4'd4 and 4'd5 name the three registers, called A, S and T. A load with any other number is ignored, and reading any other number returns zero. Lane l occupies bits [24l+23:24l] of the data buses.
- R3: Op code 2'b00 adds. It writes r1+r2 to r2 in every lane, and each lane wraps to 24 bits.
- R4: Op code 2'b01 subtracts. It writes r2-r1 to r2 in every lane, and each lane wraps to 24 bits.
- R5: Op code 2'b10 multiplies. It writes the low 24 bits of r1*r2 to r2 in every lane.
- R6: Op code 2'b11 divides. It computes r2/r1 per lane as a signed quotient truncated toward zero, and always writes the result to register T.
- R7: If any divisor lane is zero, the divide raises div0_o together with done_o and changes no register.
- R8: If either register number is invalid, the operation raises bad_reg_o together with done_o and changes no register.
- R9: done_o is a one-cycle pulse in the cycle after the write-back edge. For add, subtract, multiply and rejected operations, that edge is the first rising edge after the edge that sampled start_i.
- R10: While busy_o is high, start_i is ignored.
- R11: If a load and a write-back hit the same register on the same edge, the write-back wins. A load to a different register on that edge still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| op_i | input | 2 | Operation code |
| r1_i | input | 4 | First register number |
| r2_i | input | 4 | Second register number |
| ld_en_i | input | 1 | Load strobe |
| ld_reg_i | input | 4 | Register number for a load |
| ld_data_i | input | 96 | Four lanes of load data |
| rd_reg_i | input | 4 | Register number for the read port |
| rd_data_o | output | 96 | Combinational read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (one cycle) |
| div0_o | output | 1 | Zero divisor, valid with done_o |
| bad_reg_o | output | 1 | Invalid register number, valid with done_o |

## Verification
The write-back of an operation and a load from the surrounding logic can land on the same edge. The bench provokes this by driving the load port in the cycle right after start is taken, which is when add, subtract and multiply commit. It does this once with the load aimed at the destination register and once with the load aimed at another register. A scoreboard model applies the write-back-wins rule and checks all three registers through the read port when done arrives. A start pulse driven in the middle of a long divide checks that a second request cannot slip into the same window.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } vop_e;

  localparam int NUM_VREG = 3;
  localparam int VIDX_W   = 2;
  localparam int REGNUM_A = 0;
  localparam int REGNUM_S = 4;
  localparam int REGNUM_T = 5;
  localparam logic [VIDX_W-1:0] IDX_T = 2'd2;

  typedef struct packed {
    logic              ok;
    logic [VIDX_W-1:0] idx;
  } vsel_t;
endpackage

// File: rtl/vreg_file.sv
module vreg_file #(
  parameter int NREG = 3,
  parameter int VW   = 96,
  parameter int IW   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cwe_i,
  input  logic [IW-1:0]            cidx_i,
  input  logic [VW-1:0]            cdata_i,
  input  logic                     lwe_i,
  input  logic [IW-1:0]            lidx_i,
  input  logic [VW-1:0]            ldata_i,
  output logic [NREG-1:0][VW-1:0]  regs_o
);
  logic [NREG-1:0][VW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int g = 0; g < NREG; g++) begin
        // commit outranks load on the same register
        if (cwe_i && cidx_i == IW'(g))      mem_q[g] <= cdata_i;
        else if (lwe_i && lidx_i == IW'(g)) mem_q[g] <= ldata_i;
      end
    end
  end

  assign regs_o = mem_q;
endmodule

// File: rtl/vlane_ops.sv
module vlane_ops
  import vec_alu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LW    = 24
) (
  input  vop_e                op_i,
  input  logic [LANES*LW-1:0] a_i,
  input  logic [LANES*LW-1:0] b_i,
  output logic [LANES*LW-1:0] res_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] a, b, r;
    assign a = a_i[l*LW +: LW];
    assign b = b_i[l*LW +: LW];
    always_comb begin
      case (op_i)
        OP_ADD:  r = a + b;
        OP_SUB:  r = b - a;
        OP_MUL:  r = a * b;
        default: r = b;
      endcase
    end
    assign res_o[l*LW +: LW] = r;
  end
endmodule

// File: rtl/vseq_div.sv
module vseq_div #(
  parameter int LW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [LW-1:0] num_i,
  input  logic [LW-1:0] den_i,
  output logic          valid_o,
  output logic [LW-1:0] quo_o
);
  localparam int CW = $clog2(LW + 1);

  logic          run_q, neg_q, valid_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] den_q, quo_q, rem_q, res_q;
  logic [LW:0]   trial, rem_d;
  logic [LW-1:0] quo_d, num_mag, den_mag;
  logic          ge;

  assign num_mag = num_i[LW-1] ? -num_i : num_i;
  assign den_mag = den_i[LW-1] ? -den_i : den_i;

  always_comb begin
    trial = {rem_q, quo_q[LW-1]};
    ge    = trial >= {1'b0, den_q};
    rem_d = ge ? trial - {1'b0, den_q} : trial;
    quo_d = {quo_q[LW-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; neg_q <= 1'b0; valid_q <= 1'b0;
      cnt_q <= '0; den_q <= '0; quo_q <= '0; rem_q <= '0; res_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (go_i) begin
        run_q <= 1'b1;
        cnt_q <= CW'(LW);
        rem_q <= '0;
        quo_q <= num_mag;
        den_q <= den_mag;
        neg_q <= num_i[LW-1] ^ den_i[LW-1];
      end else if (run_q) begin
        rem_q <= rem_d[LW-1:0];
        quo_q <= quo_d;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
          res_q   <= neg_q ? -quo_d : quo_d;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign quo_o   = res_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LW));
endmodule

// File: rtl/vec_alu.sv
module vec_alu
  import vec_alu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LW    = 24,
  parameter int RW    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [RW-1:0]       r1_i,
  input  logic [RW-1:0]       r2_i,
  input  logic                ld_en_i,
  input  logic [RW-1:0]       ld_reg_i,
  input  logic [LANES*LW-1:0] ld_data_i,
  input  logic [RW-1:0]       rd_reg_i,
  output logic [LANES*LW-1:0] rd_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                div0_o,
  output logic                bad_reg_o
);
  localparam int VW   = LANES * LW;
  localparam int NREG = NUM_VREG;
  localparam int LNW  = $clog2(LANES);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_DIV} st_e;

  function automatic vsel_t decode_reg(input logic [RW-1:0] n);
    vsel_t s;
    s.ok  = 1'b1;
    s.idx = '0;
    if (n == RW'(REGNUM_A))      s.idx = 2'd0;
    else if (n == RW'(REGNUM_S)) s.idx = 2'd1;
    else if (n == RW'(REGNUM_T)) s.idx = 2'd2;
    else                         s.ok  = 1'b0;
    return s;
  endfunction

  st_e                     st_q;
  vop_e                    op_q;
  vsel_t                   r1_q, r2_q, ld_sel, rd_sel;
  logic [LNW-1:0]          lane_q;
  logic                    go_q, done_q, div0_q, bad_q;
  logic [VW-1:0]           opa_q, opb_q, qbuf_q;
  logic [NREG-1:0][VW-1:0] regs_w;
  logic [VW-1:0]           src1, src2, alu_res, div_full, cdata;
  logic                    cwe, dz, regs_ok, dv_valid;
  logic [VIDX_W-1:0]       cidx;
  logic [LW-1:0]           dquo;

  assign ld_sel  = decode_reg(ld_reg_i);
  assign rd_sel  = decode_reg(rd_reg_i);
  assign regs_ok = r1_q.ok && r2_q.ok;
  assign src1    = r1_q.ok ? regs_w[r1_q.idx] : '0;
  assign src2    = r2_q.ok ? regs_w[r2_q.idx] : '0;

  always_comb begin
    dz = 1'b0;
    for (int l = 0; l < LANES; l++) dz |= (src1[l*LW +: LW] == '0);
  end

  vlane_ops #(.LANES(LANES), .LW(LW)) u_ops (
    .op_i (op_q),
    .a_i  (src1),
    .b_i  (src2),
    .res_o(alu_res)
  );

  vseq_div #(.LW(LW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .num_i  (opb_q[lane_q*LW +: LW]),
    .den_i  (opa_q[lane_q*LW +: LW]),
    .valid_o(dv_valid),
    .quo_o  (dquo)
  );

  always_comb begin
    div_full = qbuf_q;
    div_full[lane_q*LW +: LW] = dquo;
  end

  always_comb begin
    cwe   = 1'b0;
    cidx  = r2_q.idx;
    cdata = alu_res;
    if (st_q == ST_EXEC && regs_ok && op_q != OP_DIV) begin
      cwe = 1'b1;
    end else if (st_q == ST_DIV && dv_valid && lane_q == LNW'(LANES - 1)) begin
      cwe   = 1'b1;
      cidx  = IDX_T;
      cdata = div_full;
    end
  end

  vreg_file #(.NREG(NREG), .VW(VW), .IW(VIDX_W)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cwe_i  (cwe),
    .cidx_i (cidx),
    .cdata_i(cdata),
    .lwe_i  (ld_en_i && ld_sel.ok),
    .lidx_i (ld_sel.idx),
    .ldata_i(ld_data_i),
    .regs_o (regs_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_ADD;
      r1_q   <= '0;
      r2_q   <= '0;
      lane_q <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      div0_q <= 1'b0;
      bad_q  <= 1'b0;
      opa_q  <= '0;
      opb_q  <= '0;
      qbuf_q <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      div0_q <= 1'b0;
      bad_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          op_q <= vop_e'(op_i);
          r1_q <= decode_reg(r1_i);
          r2_q <= decode_reg(r2_i);
          st_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (!regs_ok) begin
            bad_q <= 1'b1; done_q <= 1'b1; st_q <= ST_IDLE;
          end else if (op_q != OP_DIV) begin
            done_q <= 1'b1; st_q <= ST_IDLE;
          end else if (dz) begin
            // every divisor lane is screened before any quotient exists
            div0_q <= 1'b1; done_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            opa_q  <= src1;
            opb_q  <= src2;
            lane_q <= '0;
            go_q   <= 1'b1;
            st_q   <= ST_DIV;
          end
        end
        ST_DIV: if (dv_valid) begin
          qbuf_q[lane_q*LW +: LW] <= dquo;
          if (lane_q == LNW'(LANES - 1)) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            lane_q <= lane_q + 1'b1;
            go_q   <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = st_q != ST_IDLE;
  assign done_o    = done_q;
  assign div0_o    = div0_q;
  assign bad_reg_o = bad_q;
  assign rd_data_o = rd_sel.ok ? regs_w[rd_sel.idx] : '0;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  flag_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div0_o || bad_reg_o) |-> done_o);
  // R7
  div0_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div0_o |-> !$past(cwe));
  // R10
  div_result_in_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_valid |-> (st_q == ST_DIV));
endmodule

// File: tb/sim_vec_alu.sv
module sim_vec_alu;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int LW    = 24;
  localparam int VW    = LANES * LW;

  typedef struct packed {
    logic                div0;
    logic                bad;
    logic                chk_lat;
    logic [31:0]         t0;
    logic [2:0][VW-1:0]  regs;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [3:0]    r1_i = '0, r2_i = '0;
  logic          ld_en_i = 1'b0;
  logic [3:0]    ld_reg_i = '0;
  logic [VW-1:0] ld_data_i = '0;
  logic [3:0]    rd_reg_i = '0;
  logic [VW-1:0] rd_data_o;
  logic          busy_o, done_o, div0_o, bad_reg_o;

  vec_alu u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int            n_chk = 0, n_bad = 0;
  logic [31:0]   cyc = 0;
  exp_t          sbq[$];
  logic [VW-1:0] mdl [3];
  logic [3:0]    regnum [3] = '{4'd0, 4'd4, 4'd5};

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [3:0] n);
    if (n == 4'd0) return 0;
    if (n == 4'd4) return 1;
    if (n == 4'd5) return 2;
    return -1;
  endfunction

  function automatic logic [VW-1:0] vec(input int l0, l1, l2, l3);
    logic [VW-1:0] v;
    v[0*LW +: LW] = l0[LW-1:0];
    v[1*LW +: LW] = l1[LW-1:0];
    v[2*LW +: LW] = l2[LW-1:0];
    v[3*LW +: LW] = l3[LW-1:0];
    return v;
  endfunction

  function automatic logic [VW-1:0] lane_math(input int op, input logic [VW-1:0] v1, v2);
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      logic signed [LW-1:0] a, b;
      int ai, bi, ri;
      a = v1[l*LW +: LW];
      b = v2[l*LW +: LW];
      ai = a;
      bi = b;
      case (op)
        0: ri = ai + bi;
        1: ri = bi - ai;
        2: ri = ai * bi;
        default: ri = bi / ai;
      endcase
      r[l*LW +: LW] = ri[LW-1:0];
    end
    return r;
  endfunction

  // monitor: pops one expectation per done pulse
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R10 unexpected done", VW'(done_o), '0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(div0_o == e.div0, "R7 div0 flag", VW'(div0_o), VW'(e.div0));
        chk(bad_reg_o == e.bad, "R8 bad_reg flag", VW'(bad_reg_o), VW'(e.bad));
        if (e.chk_lat) chk(cyc - e.t0 == 1, "R9 done latency", VW'(cyc - e.t0), VW'(1));
        for (int r = 0; r < 3; r++) begin
          rd_reg_i = regnum[r];
          #1;
          chk(rd_data_o == e.regs[r], "R3-R6 scoreboard reg", rd_data_o, e.regs[r]);
        end
      end
    end
  end

  task automatic load(input logic [3:0] rn, input logic [VW-1:0] d);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_reg_i = rn; ld_data_i = d;
    @(negedge clk_i);
    ld_en_i = 1'b0;
    if (idx_of(rn) >= 0) mdl[idx_of(rn)] = d;
  endtask

  task automatic rdchk(input logic [3:0] rn, input logic [VW-1:0] exp, input string req);
    @(negedge clk_i);
    rd_reg_i = rn;
    #1;
    chk(rd_data_o == exp, req, rd_data_o, exp);
  endtask

  // driver: models the result, queues it, then issues the op
  task automatic run_op(input int op, input logic [3:0] r1, r2, input bit ld,
                        input logic [3:0] ldr, input logic [VW-1:0] ldd, input bit wait_end);
    exp_t e;
    int i1, i2, li, dst;
    bit commit;
    i1 = idx_of(r1); i2 = idx_of(r2); li = idx_of(ldr);
    e = '0;
    commit = 1'b0; dst = -1;
    if (i1 < 0 || i2 < 0) e.bad = 1'b1;
    else if (op == 3) begin
      bit z = 1'b0;
      for (int l = 0; l < LANES; l++) if (mdl[i1][l*LW +: LW] == '0) z = 1'b1;
      if (z) e.div0 = 1'b1;
      else begin mdl[2] = lane_math(3, mdl[i1], mdl[i2]); end
    end else begin
      commit = 1'b1; dst = i2;
      mdl[i2] = lane_math(op, mdl[i1], mdl[i2]);
    end
    if (ld && li >= 0 && !(commit && dst == li)) mdl[li] = ldd;
    e.chk_lat = (op != 3) || e.bad;
    for (int r = 0; r < 3; r++) e.regs[r] = mdl[r];
    @(negedge clk_i);
    start_i = 1'b1; op_i = op[1:0]; r1_i = r1; r2_i = r2;
    @(negedge clk_i);
    start_i = 1'b0;
    e.t0 = cyc;
    sbq.push_back(e);
    if (ld) begin ld_en_i = 1'b1; ld_reg_i = ldr; ld_data_i = ldd; end
    @(negedge clk_i);
    ld_en_i = 1'b0;
    if (wait_end) begin
      wait (sbq.size() == 0);
      @(negedge clk_i);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 3; r++) mdl[r] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk({busy_o, done_o, div0_o, bad_reg_o} == 4'b0, "R1 idle outputs",
        VW'({busy_o, done_o, div0_o, bad_reg_o}), '0);
    for (int r = 0; r < 3; r++) rdchk(regnum[r], '0, "R1 reset regs");

    // R2 loads and invalid numbers
    load(4'd0, vec(1, 2, 3, 4));
    load(4'd4, vec(5, 6, 7, 8));
    load(4'd5, vec(-1, -2, -3, -4));
    for (int r = 0; r < 3; r++) rdchk(regnum[r], mdl[r], "R2 load readback");
    load(4'd7, vec(9, 9, 9, 9));
    for (int r = 0; r < 3; r++) rdchk(regnum[r], mdl[r], "R2 invalid load ignored");
    rdchk(4'd7, '0, "R2 invalid read zero");

    // R3 add into r2, R4 sub r2-r1
    run_op(0, 4'd4, 4'd0, 0, 4'd0, '0, 1);
    chk(mdl[0] == vec(6, 8, 10, 12), "R3 add model", mdl[0], vec(6, 8, 10, 12));
    run_op(1, 4'd0, 4'd4, 0, 4'd0, '0, 1);
    load(4'd0, vec(32'h7FFFFF, 32'h7FFFFF, -1, 0));
    load(4'd4, vec(1, 2, 1, -5));
    run_op(0, 4'd0, 4'd4, 0, 4'd0, '0, 1);   // R3 wrap
    rdchk(4'd4, vec(32'h800000, 32'h800001, 0, -5), "R3 wrap lanes");

    // R5 multiply low bits
    load(4'd0, vec(1000, -3, 32'h7FFFFF, 4096));
    load(4'd5, vec(5000, 7, 2, 4096));
    run_op(2, 4'd0, 4'd5, 0, 4'd0, '0, 1);

    // R6 divide lands in T
    load(4'd0, vec(7, -7, 3, -1));
    load(4'd4, vec(100, 100, -100, 32'h800000));
    run_op(3, 4'd0, 4'd4, 0, 4'd0, '0, 1);
    rdchk(4'd5, vec(14, -14, -33, 32'h800000), "R6 quotient in T");
    run_op(3, 4'd0, 4'd0, 0, 4'd0, '0, 1);

    // R7 zero divisor in lane 2
    load(4'd0, vec(2, 3, 0, 4));
    run_op(3, 4'd0, 4'd4, 0, 4'd0, '0, 1);

    // R8 invalid register numbers
    run_op(0, 4'd3, 4'd0, 0, 4'd0, '0, 1);
    run_op(1, 4'd0, 4'd6, 0, 4'd0, '0, 1);

    // R10 start during a divide
    load(4'd0, vec(3, 5, -9, 11));
    run_op(3, 4'd0, 4'd4, 0, 4'd0, '0, 0);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 1'b1, "R10 busy during divide", VW'(busy_o), VW'(1));
    start_i = 1'b1; op_i = 2'b00; r1_i = 4'd0; r2_i = 4'd4;
    @(negedge clk_i);
    start_i = 1'b0;
    wait (sbq.size() == 0);
    repeat (4) @(negedge clk_i);
    chk(busy_o == 1'b0, "R10 idle after divide", VW'(busy_o), '0);

    // R11 load and commit on the same edge
    run_op(0, 4'd0, 4'd4, 1, 4'd4, vec(77, 77, 77, 77), 1);
    run_op(1, 4'd5, 4'd0, 1, 4'd5, vec(-8, 8, -8, 8), 1);
    rdchk(4'd5, vec(-8, 8, -8, 8), "R11 other reg load kept");

    repeat (3) @(negedge clk_i);
    chk(sbq.size() == 0, "R9 all done seen", VW'(sbq.size()), '0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule